// File: doc/BRIEF.md
# Scratch Mirror and Coherency Side-Effect Unit

This unit watches the register write stream of a command engine and reacts to a small set of addresses. The stream carries an address and a 32-bit value. Eight consecutive scratch addresses can be mirrored out to memory. Each has its own enable bit in a scratch enable register, and the memory word lands at a programmable scratch base address plus four times the scratch number. The unit sends the word to memory in big-endian byte order, so it byte-swaps the value. One memory write request can be outstanding at a time. It stays valid until memory accepts it. While it waits, another mirrored write stalls the register write port. Writes to any other address pass through with no side effect.

The unit also keeps a host coherency status word, with a base and a size beside it. Writing the status word stores the value with bit 31 forced to one, which marks the status as dirty. A coherency request pulse reads the status. If bit 31 is clear, the unit answers with no action. Otherwise it reports the vertex-cache and texture-cache action flags, the base, the size and the status word, and then clears the status. Flushing the caches is the job of whatever consumes the report.

Top module: `scratch_coher_fx`

## Requirements
- R1: Scratch n (0..7) sits at address SCR0_ADDR+n. A write to scratch n whose bit n in the enable register (MASK_ADDR) is set raises mem_valid on the clock edge that accepts the write.
- R2: A scratch write whose enable bit is clear raises no memory request.
- R3: mem_addr equals the scratch base register (SBASE_ADDR) plus 4*n.
- R4: mem_data is the written value with its bytes reversed: bits 7:0 of the value appear at bits 31:24.
- R5: A write to the status register (CSTAT_ADDR) stores the value with bit 31 set. The next coherency request reports that word on coh_stat.
- R6: A coherency request that sees status bit 31 clear produces, one cycle later, coh_done=1, coh_acted=0, coh_vc=0 and coh_tc=0.
- R7: A coherency request that sees status bit 31 set produces, one cycle later, coh_done=1 and coh_acted=1. It reports coh_vc = status bit 24, coh_tc = status bit 25, the base (CBASE_ADDR) and the size (CSIZE_ADDR), and it clears the status to zero, so that an immediate second request reports coh_acted=0.
- R8: While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_data hold steady.
- R9: While a request is pending and mem_ready is low, wr_ready is low for a write that would mirror and high for any other write.
- R10: A write to an address outside the eight scratch and five control addresses raises no memory request and leaves the coherency status unchanged.
- R11: After reset, mem_valid=0, coh_done=0, the status is zero and every scratch enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write value |
| wr_ready | output | 1 | Write accepted this cycle when high |
| mem_valid | output | 1 | Memory write request pending |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 32 | Byte-swapped mirrored value |
| mem_ready | input | 1 | Memory accepts the pending request |
| coh_req | input | 1 | Coherency request, one per cycle high |
| coh_done | output | 1 | Coherency answer strobe |
| coh_acted | output | 1 | Status was dirty and has been cleared |
| coh_vc | output | 1 | Vertex-cache action flag |
| coh_tc | output | 1 | Texture-cache action flag |
| coh_base | output | 32 | Reported coherency base |
| coh_size | output | 32 | Reported coherency size |
| coh_stat | output | 32 | Reported status word |

## Verification
The case that is hardest to reach is a second mirrored write that arrives while the first request is still waiting on memory. The bench holds mem_ready low after one mirror, presents a write to a second scratch register and checks that wr_ready is low, while a write to an ordinary address is still accepted. It then checks that the pending request has not moved, and raises mem_ready so that the stalled write loads in the same edge. Sweeps over several enable patterns cover all eight scratch numbers in both the enabled and the disabled state.

// File: rtl/scratch_coher_fx.sv
module scratch_coher_fx #(
  parameter int ADDR_W = 16,
  parameter int NSCR = 8,
  parameter logic [ADDR_W-1:0] SCR0_ADDR = 16'h0100,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h0110,
  parameter logic [ADDR_W-1:0] SBASE_ADDR = 16'h0111,
  parameter logic [ADDR_W-1:0] CSTAT_ADDR = 16'h0120,
  parameter logic [ADDR_W-1:0] CBASE_ADDR = 16'h0121,
  parameter logic [ADDR_W-1:0] CSIZE_ADDR = 16'h0122,
  parameter int VC_BIT = 24,
  parameter int TC_BIT = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              wr_ready,
  output logic              mem_valid,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_data,
  input  logic              mem_ready,
  input  logic              coh_req,
  output logic              coh_done,
  output logic              coh_acted,
  output logic              coh_vc,
  output logic              coh_tc,
  output logic [31:0]       coh_base,
  output logic [31:0]       coh_size,
  output logic [31:0]       coh_stat
);
  localparam int IDX_W = (NSCR > 1) ? $clog2(NSCR) : 1;

  logic [NSCR-1:0]   scr_mask;
  logic [31:0]       scr_base;
  logic [31:0]       stat_q, cbase_q, csize_q;
  logic [ADDR_W-1:0] scr_off;
  logic [IDX_W-1:0]  scr_idx;
  logic              scr_hit, mirror, issue, stat_wr, stat_dirty;

  assign scr_off    = wr_addr - SCR0_ADDR;
  assign scr_hit    = scr_off < ADDR_W'(NSCR);
  assign scr_idx    = scr_off[IDX_W-1:0];
  assign mirror     = scr_hit && scr_mask[scr_idx];
  assign wr_ready   = !mirror || !mem_valid || mem_ready;
  assign issue      = wr_en && wr_ready && mirror;
  assign stat_wr    = wr_en && (wr_addr == CSTAT_ADDR);
  assign stat_dirty = stat_q[31];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scr_mask <= '0;
      scr_base <= '0;
      cbase_q  <= '0;
      csize_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == MASK_ADDR)  scr_mask <= wr_data[NSCR-1:0];
      if (wr_addr == SBASE_ADDR) scr_base <= wr_data;
      if (wr_addr == CBASE_ADDR) cbase_q  <= wr_data;
      if (wr_addr == CSIZE_ADDR) csize_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (issue) begin
      mem_valid <= 1'b1;
      mem_addr  <= scr_base + (32'(scr_idx) << 2);
      mem_data  <= {wr_data[7:0], wr_data[15:8], wr_data[23:16], wr_data[31:24]};
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q    <= '0;
      coh_done  <= 1'b0;
      coh_acted <= 1'b0;
      coh_vc    <= 1'b0;
      coh_tc    <= 1'b0;
      coh_base  <= '0;
      coh_size  <= '0;
      coh_stat  <= '0;
    end else begin
      coh_done <= coh_req;
      if (coh_req) begin
        coh_acted <= stat_dirty;
        coh_vc    <= stat_dirty && stat_q[VC_BIT];
        coh_tc    <= stat_dirty && stat_q[TC_BIT];
        coh_base  <= cbase_q;
        coh_size  <= csize_q;
        coh_stat  <= stat_q;
      end
      if (stat_wr)                    stat_q <= wr_data | 32'h8000_0000;
      else if (coh_req && stat_dirty) stat_q <= '0;
    end
  end

  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  a_r2_only_on_scratch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(wr_en && scr_hit));

  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && mirror) |-> !wr_ready);

  a_r5_dirty_mark: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> stat_q[31]);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_req && !stat_wr) |=> (coh_done && stat_q == 32'd0));

  a_r6_idle_report: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_done && !coh_acted) |-> (!coh_vc && !coh_tc));
endmodule

// File: tb/scratch_coher_fx_tb.sv
`timescale 1ns/100ps
module scratch_coher_fx_tb_top;
  localparam logic [15:0] SCR0 = 16'h0100, MASK = 16'h0110, SBASE = 16'h0111;
  localparam logic [15:0] CSTAT = 16'h0120, CBASE = 16'h0121, CSIZE = 16'h0122;

  logic clk = 0, rst_n = 0, wr_en = 0, mem_ready = 0, coh_req = 0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic wr_ready, mem_valid, coh_done, coh_acted, coh_vc, coh_tc;
  logic [31:0] mem_addr, mem_data, coh_base, coh_size, coh_stat;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scratch_coher_fx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .coh_req(coh_req), .coh_done(coh_done), .coh_acted(coh_acted),
    .coh_vc(coh_vc), .coh_tc(coh_tc), .coh_base(coh_base), .coh_size(coh_size),
    .coh_stat(coh_stat));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic accept();
    @(negedge clk); mem_ready = 1;
    @(posedge clk); #1; mem_ready = 0;
  endtask

  task automatic coh();
    @(negedge clk); coh_req = 1;
    @(posedge clk); #1; coh_req = 0;
  endtask

  function automatic logic [31:0] swp(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] masks [4];
    masks[0] = 8'hA5; masks[1] = 8'hFF; masks[2] = 8'h00; masks[3] = 8'h5A;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R11 reset state
    chk(mem_valid == 0, "R11 mem_valid", 32'(mem_valid), 0);
    chk(coh_done == 0, "R11 coh_done", 32'(coh_done), 0);
    chk(wr_ready == 1, "R11 wr_ready", 32'(wr_ready), 1);
    // R11 mask clear: scratch write right after reset does not mirror
    wr(SCR0 + 16'd3, 32'h1111_2222);
    chk(mem_valid == 0, "R11 mask clear", 32'(mem_valid), 0);
    coh();
    chk(coh_done && !coh_acted, "R11/R6 status zero", 32'(coh_acted), 0);
    chk(!coh_vc && !coh_tc, "R6 flags", {30'd0, coh_vc, coh_tc}, 0);

    // R1..R4 sweep over masks and scratch numbers
    for (int m = 0; m < 4; m++) begin
      logic [31:0] base;
      base = 32'h0004_0000 + 32'(m) * 32'h100;
      wr(MASK, {24'd0, masks[m]});
      wr(SBASE, base);
      for (int n = 0; n < 8; n++) begin
        logic [31:0] d;
        d = 32'h1020_3040 * (n + 1) + 32'(m) * 32'h0107_0305;
        wr(SCR0 + 16'(n), d);
        if (masks[m][n]) begin
          chk(mem_valid == 1, "R1 mirror raised", 32'(mem_valid), 1);
          chk(mem_addr == base + 32'(4 * n), "R3 address", mem_addr, base + 32'(4 * n));
          chk(mem_data == swp(d), "R4 byte swap", mem_data, swp(d));
          accept();
          chk(mem_valid == 0, "R1 accepted", 32'(mem_valid), 0);
        end else begin
          chk(mem_valid == 0, "R2 masked off", 32'(mem_valid), 0);
        end
      end
    end

    // R8/R9 stall case
    wr(MASK, 32'h0000_00FF);
    wr(SBASE, 32'h0009_0000);
    wr(SCR0 + 16'd2, 32'hDEAD_BEEF);
    @(negedge clk);
    wr_en = 1; wr_addr = 16'h0300; wr_data = 32'h5;
    #1 chk(wr_ready == 1, "R9 other write not stalled", 32'(wr_ready), 1);
    @(posedge clk); #1;
    @(negedge clk);
    wr_en = 1; wr_addr = SCR0 + 16'd3; wr_data = 32'hCAFE_0123;
    #1 chk(wr_ready == 0, "R9 mirror stalled", 32'(wr_ready), 0);
    repeat (3) @(posedge clk);
    #1;
    chk(mem_valid == 1, "R8 still valid", 32'(mem_valid), 1);
    chk(mem_addr == 32'h0009_0008, "R8 addr held", mem_addr, 32'h0009_0008);
    chk(mem_data == swp(32'hDEAD_BEEF), "R8 data held", mem_data, swp(32'hDEAD_BEEF));
    @(negedge clk); mem_ready = 1;
    #1 chk(wr_ready == 1, "R9 released", 32'(wr_ready), 1);
    @(posedge clk); #1; mem_ready = 0; wr_en = 0;
    chk(mem_valid == 1, "R1 stalled write issued", 32'(mem_valid), 1);
    chk(mem_addr == 32'h0009_000C, "R3 stalled addr", mem_addr, 32'h0009_000C);
    chk(mem_data == swp(32'hCAFE_0123), "R4 stalled data", mem_data, swp(32'hCAFE_0123));
    accept();

    // R5/R7 coherency
    wr(CBASE, 32'h0123_4000);
    wr(CSIZE, 32'h0000_2000);
    wr(CSTAT, 32'h0300_0000);
    coh();
    chk(coh_done && coh_acted, "R7 acted", 32'(coh_acted), 1);
    chk(coh_stat == 32'h8300_0000, "R5 status word", coh_stat, 32'h8300_0000);
    chk(coh_vc && coh_tc, "R7 vc tc", {30'd0, coh_vc, coh_tc}, 3);
    chk(coh_base == 32'h0123_4000, "R7 base", coh_base, 32'h0123_4000);
    chk(coh_size == 32'h0000_2000, "R7 size", coh_size, 32'h0000_2000);
    coh();
    chk(coh_done && !coh_acted, "R7 cleared", 32'(coh_acted), 0);
    wr(CSTAT, 32'h0100_0005);
    coh();
    chk(coh_stat == 32'h8100_0005, "R5 status vc", coh_stat, 32'h8100_0005);
    chk(coh_vc && !coh_tc, "R7 vc only", {30'd0, coh_vc, coh_tc}, 2);
    wr(CSTAT, 32'h0200_0000);
    coh();
    chk(!coh_vc && coh_tc, "R7 tc only", {30'd0, coh_vc, coh_tc}, 1);
    wr(CSTAT, 32'h0);
    coh();
    chk(coh_acted && coh_stat == 32'h8000_0000, "R5 zero write dirty", coh_stat, 32'h8000_0000);
    chk(!coh_vc && !coh_tc, "R7 no flags", {30'd0, coh_vc, coh_tc}, 0);

    // R10 passthrough
    for (int k = 0; k < 4; k++) begin
      wr(16'h0200 + 16'(k * 37), 32'hFFFF_FFFF);
      chk(mem_valid == 0, "R10 no mirror", 32'(mem_valid), 0);
    end
    coh();
    chk(coh_done && !coh_acted, "R10 status untouched", 32'(coh_acted), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule